// File: doc/BRIEF.md
# Receive Prepend Port Demultiplexer

This block terminates the receive direction of a push-style packet bus between a physical layer device and a link layer device. The link side never polls or selects. The sender opens each transfer with one bus word flagged as an address word. Its low bits name the port that the following words belong to. No address pins or packet-available pins exist, so port identity reaches the receiver only through this in-band prefix word.

The block remembers the most recent port prefix and stamps it onto every accepted data word. It registers each word together with its start and end markers and a byte-valid mask, which it derives from the modulo field of a final word. It keeps one in-packet bit per port. A sender can therefore switch ports in the middle of a packet and return later, and the block still knows which packets are open. Two protocol faults are reported: a data word that arrives before any prefix word, and a new start on a port whose previous packet never ended.

Top module: `rx_prepend_demux`

## Requirements
- R1: An accepted word with addr_i high loads data_i[7:0] as the current port, ignores the upper bits, and produces no output word.
- R2: An accepted data word appears on the outputs one clock later with vld_o high, data_o equal to data_i, port_o equal to the current port, and sop_o/eop_o copied from the inputs.
- R3: A word is accepted only when en_i and valid_i are both high. Other words, including address words, change neither the outputs nor the current port.
- R4: be_o bit 3 marks data bits 31:24, which is the first byte on the bus. A word without eop gives be_o=1111. An eop word decodes mod_i: 0→1111, 1→1000, 2→1100, 3→1110.
- R5: An accepted data word that arrives before any address word since reset raises noaddr_err_o for one cycle, and vld_o stays low.
- R6: An accepted sop word on a port whose packet is open (sop seen, no eop yet) is output with err_o high. Otherwise err_o is low.
- R7: Open-packet state is held per port and survives address words that switch to other ports.
- R8: An address word may directly follow an eop word, and a data word may directly follow the address word, with no idle cycles between them.
- R9: Reset clears the outputs, the have-address state and all per-port open-packet state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Receive enable |
| valid_i | input | 1 | Bus word present |
| addr_i | input | 1 | Word is a port prefix |
| sop_i | input | 1 | Start of packet |
| eop_i | input | 1 | End of packet |
| mod_i | input | 2 | Valid-byte count on eop word (0 means 4) |
| data_i | input | 32 | Bus word |
| vld_o | output | 1 | Output word valid |
| data_o | output | 32 | Output data |
| port_o | output | 8 | Port tag |
| sop_o | output | 1 | Start marker |
| eop_o | output | 1 | End marker |
| be_o | output | 4 | Byte-valid mask, bit 3 = first byte |
| err_o | output | 1 | Open packet on this port was restarted |
| noaddr_err_o | output | 1 | Data word seen before any prefix |

## Verification
The stimulus opens a packet on one port, switches to a second port in the middle of it, and then returns. A wrong tag or lost open state shows up there as a bad port_o or a spurious err_o. Words with en_i low or valid_i low are mixed into the stream, among them an address word that must not move the port. An address word follows an eop directly, so any required gap would be exposed. All four modulo codes appear on eop words, which separates the mask decode from a shifted or reversed one. A restart on an open port, and a reset taken in the middle of a packet, tell the error paths apart from the normal start path.

// File: rtl/rx_pd_pkg.sv
package rx_pd_pkg;
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_ADDR   = 2'd1,
    WK_DATA   = 2'd2,
    WK_ORPHAN = 2'd3
  } word_kind_e;
endpackage

// File: rtl/rx_pd_prepend.sv
module rx_pd_prepend #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [PORT_W-1:0] port_o,
  output logic              have_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o <= '0;
      have_o <= 1'b0;
    end else if (load_i) begin
      port_o <= port_i;
      have_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_pd_track.sv
module rx_pd_track #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              clash_o
);
  localparam int unsigned NUM_PORTS = 1 << PORT_W;

  logic [NUM_PORTS-1:0] open_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[p] <= 1'b0;
      end else if (upd_i && (port_i == PORT_W'(p))) begin
        if (eop_i)      open_q[p] <= 1'b0;
        else if (sop_i) open_q[p] <= 1'b1;
      end
    end
  end

  assign clash_o = sop_i && open_q[port_i];
endmodule

// File: rtl/rx_pd_mask.sv
module rx_pd_mask #(
  parameter int unsigned BYTES = 4
) (
  input  logic                       eop_i,
  input  logic [$clog2(BYTES)-1:0]   mod_i,
  output logic [BYTES-1:0]           be_o
);
  localparam int unsigned MOD_W = $clog2(BYTES);

  logic [MOD_W:0] nvalid;
  assign nvalid = (mod_i == '0) ? (MOD_W+1)'(BYTES) : {1'b0, mod_i};

  // bit BYTES-1 is the first byte on the bus
  for (genvar b = 0; b < BYTES; b++) begin : g_be
    assign be_o[b] = !eop_i || ((32'(b) + 32'(nvalid)) >= 32'(BYTES));
  end
endmodule

// File: rtl/rx_prepend_demux.sv
module rx_prepend_demux
  import rx_pd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PORT_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic                            valid_i,
  input  logic                            addr_i,
  input  logic                            sop_i,
  input  logic                            eop_i,
  input  logic [$clog2(DATA_W/8)-1:0]     mod_i,
  input  logic [DATA_W-1:0]               data_i,
  output logic                            vld_o,
  output logic [DATA_W-1:0]               data_o,
  output logic [PORT_W-1:0]               port_o,
  output logic                            sop_o,
  output logic                            eop_o,
  output logic [DATA_W/8-1:0]             be_o,
  output logic                            err_o,
  output logic                            noaddr_err_o
);
  localparam int unsigned BYTES = DATA_W / 8;

  word_kind_e        kind;
  logic              have_addr;
  logic [PORT_W-1:0] cur_port;
  logic              clash;
  logic [BYTES-1:0]  be;

  always_comb begin
    if (!(en_i && valid_i)) kind = WK_IDLE;
    else if (addr_i)        kind = WK_ADDR;
    else if (have_addr)     kind = WK_DATA;
    else                    kind = WK_ORPHAN;
  end

  rx_pd_prepend #(.PORT_W(PORT_W)) u_prepend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (kind == WK_ADDR),
    .port_i (data_i[PORT_W-1:0]),
    .port_o (cur_port),
    .have_o (have_addr)
  );

  rx_pd_track #(.PORT_W(PORT_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (kind == WK_DATA),
    .port_i  (cur_port),
    .sop_i   (sop_i),
    .eop_i   (eop_i),
    .clash_o (clash)
  );

  rx_pd_mask #(.BYTES(BYTES)) u_mask (
    .eop_i (eop_i),
    .mod_i (mod_i),
    .be_o  (be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      data_o       <= '0;
      port_o       <= '0;
      sop_o        <= 1'b0;
      eop_o        <= 1'b0;
      be_o         <= '0;
      err_o        <= 1'b0;
      noaddr_err_o <= 1'b0;
    end else begin
      vld_o        <= (kind == WK_DATA);
      noaddr_err_o <= (kind == WK_ORPHAN);
      if (kind == WK_DATA) begin
        data_o <= data_i;
        port_o <= cur_port;
        sop_o  <= sop_i;
        eop_o  <= eop_i;
        be_o   <= be;
        err_o  <= clash;
      end else begin
        sop_o  <= 1'b0;
        eop_o  <= 1'b0;
        err_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_prepend_demux_chk.sv
module rx_prepend_demux_chk #(
  parameter int unsigned BYTES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             valid_i,
  input logic             addr_i,
  input logic             vld_o,
  input logic             sop_o,
  input logic             eop_o,
  input logic [BYTES-1:0] be_o,
  input logic             err_o,
  input logic             noaddr_err_o
);
  // R5
  no_dual_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_o && noaddr_err_o));

  // R3
  gated_by_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!vld_o && !noaddr_err_o));

  // R1
  addr_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && addr_i) |=> !vld_o);

  // R4
  full_mid_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !eop_o) |-> (be_o == {BYTES{1'b1}}));

  // R4
  first_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> be_o[BYTES-1]);

  // R6
  err_on_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (vld_o && sop_o));
endmodule

bind rx_prepend_demux rx_prepend_demux_chk #(.BYTES(DATA_W/8)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .valid_i      (valid_i),
  .addr_i       (addr_i),
  .vld_o        (vld_o),
  .sop_o        (sop_o),
  .eop_o        (eop_o),
  .be_o         (be_o),
  .err_o        (err_o),
  .noaddr_err_o (noaddr_err_o)
);

// File: tb/rx_prepend_demux_tb.sv
`timescale 1ns/1ps
module rx_prepend_demux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, valid_i = 1'b0, addr_i = 1'b0, sop_i = 1'b0, eop_i = 1'b0;
  logic [1:0]  mod_i = '0;
  logic [31:0] data_i = '0;
  logic        vld_o, sop_o, eop_o, err_o, noaddr_err_o;
  logic [31:0] data_o;
  logic [7:0]  port_o;
  logic [3:0]  be_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  rx_prepend_demux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .valid_i(valid_i), .addr_i(addr_i),
    .sop_i(sop_i), .eop_i(eop_i), .mod_i(mod_i), .data_i(data_i),
    .vld_o(vld_o), .data_o(data_o), .port_o(port_o), .sop_o(sop_o), .eop_o(eop_o),
    .be_o(be_o), .err_o(err_o), .noaddr_err_o(noaddr_err_o)
  );

  // {en,valid,addr,sop,eop,mod,data, xvld,xport,xsop,xeop,xbe,xerr,xnoaddr,req}
  localparam int NV = 17;
  localparam int VW = 60;

  function automatic logic [VW-1:0] v(logic en, logic vl, logic ad, logic sp, logic ep,
      logic [1:0] md, logic [31:0] dt, logic xv, logic [7:0] xp, logic xs, logic xe,
      logic [3:0] xb, logic xr, logic xn, logic [3:0] rq);
    return {en, vl, ad, sp, ep, md, dt, xv, xp, xs, xe, xb, xr, xn, rq};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    v(1,1,0,1,0,0,32'h11111111, 0,8'h00,0,0,4'h0,0,1, 5),  // R5 data before any prefix
    v(1,1,1,0,0,0,32'h00000005, 0,8'h00,0,0,4'h0,0,0, 1),  // R1 prefix port 5
    v(1,1,0,1,0,0,32'hA0A0A0A0, 1,8'h05,1,0,4'hF,0,0, 2),  // R2 sop port 5
    v(1,1,0,0,0,0,32'hA1A1A1A1, 1,8'h05,0,0,4'hF,0,0, 2),  // R2 middle word
    v(0,1,0,0,1,1,32'hDEADBEEF, 0,8'h00,0,0,4'h0,0,0, 3),  // R3 en low, data dropped
    v(0,1,1,0,0,0,32'h00000077, 0,8'h00,0,0,4'h0,0,0, 3),  // R3 en low, prefix dropped
    v(1,1,1,0,0,0,32'h00000009, 0,8'h00,0,0,4'h0,0,0, 7),  // R7 switch mid-packet
    v(1,1,0,1,1,2,32'hB0B0B0B0, 1,8'h09,1,1,4'hC,0,0, 4),  // R4 mod 2
    v(1,1,1,0,0,0,32'h00000005, 0,8'h00,0,0,4'h0,0,0, 7),  // R7 return to port 5
    v(1,1,0,0,1,1,32'hA2A2A2A2, 1,8'h05,0,1,4'h8,0,0, 7),  // R7 R4 mod 1, port 5 kept
    v(1,1,1,0,0,0,32'h00000009, 0,8'h00,0,0,4'h0,0,0, 8),  // R8 prefix right after eop
    v(1,1,0,1,0,0,32'hC0C0C0C0, 1,8'h09,1,0,4'hF,0,0, 8),  // R8 data right after prefix
    v(1,1,0,1,0,0,32'hC1C1C1C1, 1,8'h09,1,0,4'hF,1,0, 6),  // R6 restart open port
    v(1,0,0,0,1,0,32'h99999999, 0,8'h00,0,0,4'h0,0,0, 3),  // R3 valid low
    v(1,1,0,0,1,3,32'hC2C2C2C2, 1,8'h09,0,1,4'hE,0,0, 4),  // R4 mod 3
    v(1,1,1,0,0,0,32'h123456A3, 0,8'h00,0,0,4'h0,0,0, 1),  // R1 upper bits ignored
    v(1,1,0,1,1,0,32'hD0D0D0D0, 1,8'hA3,1,1,4'hF,0,0, 4)   // R4 mod 0
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic en, logic vl, logic ad, logic sp, logic ep, logic [1:0] md,
                       logic [31:0] dt);
    en_i = en; valid_i = vl; addr_i = ad; sop_i = sp; eop_i = ep; mod_i = md; data_i = dt;
  endtask

  logic done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 vld", 32'(vld_o), 0);
    check("R9 noaddr", 32'(noaddr_err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      string r;
      e = VEC[i];
      r = $sformatf("R%0d vec%0d", e[3:0], i);
      drive(e[59], e[58], e[57], e[56], e[55], e[54:53], e[52:21]);
      @(negedge clk);
      check({r, " vld"}, 32'(vld_o), 32'(e[20]));
      check({r, " noaddr"}, 32'(noaddr_err_o), 32'(e[4]));
      if (e[20]) begin
        check({r, " data"}, data_o, e[52:21]);
        check({r, " port"}, 32'(port_o), 32'(e[19:12]));
        check({r, " sop"}, 32'(sop_o), 32'(e[11]));
        check({r, " eop"}, 32'(eop_o), 32'(e[10]));
        check({r, " be"}, 32'(be_o), 32'(e[9:6]));
        check({r, " err"}, 32'(err_o), 32'(e[5]));
      end
    end

    // R9 reset in the middle of a packet on port 3
    drive(1,1,1,0,0,0,32'h3); @(negedge clk);
    drive(1,1,0,1,0,0,32'hE0E0E0E0); @(negedge clk);
    drive(0,0,0,0,0,0,0);
    rst_n = 1'b0; @(negedge clk);
    check("R9 vld in reset", 32'(vld_o), 0);
    rst_n = 1'b1; @(negedge clk);
    drive(1,1,0,1,0,0,32'hE1E1E1E1); @(negedge clk);
    check("R9 prefix cleared", 32'(noaddr_err_o), 1);
    check("R9 prefix cleared vld", 32'(vld_o), 0);
    drive(1,1,1,0,0,0,32'h3); @(negedge clk);
    drive(1,1,0,1,0,0,32'hE2E2E2E2); @(negedge clk);
    check("R9 open state cleared err", 32'(err_o), 0);
    check("R9 port", 32'(port_o), 3);
    // R6 second sop on still-open port 3
    drive(1,1,0,1,0,0,32'hE3E3E3E3); @(negedge clk);
    check("R6 restart err", 32'(err_o), 1);
    drive(0,0,0,0,0,0,0); @(negedge clk);
    check("R3 idle vld", 32'(vld_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule